// File: doc/BRIEF.md
# NaN Propagation Selector for Double-Precision Operands

This block sits beside the datapath of a two-input binary64 arithmetic unit. It looks at both operands, sorts each one into signalling NaN, quiet NaN or ordinary value, and, when at least one is a NaN, produces the NaN the operation must return. It also raises an invalid-operation flag whenever a signalling NaN is present. When neither operand is a NaN it lowers `nan_valid`, and the surrounding datapath supplies the result.

Different architectures disagree about which NaN wins when both operands are NaNs. For that reason the choice is made at run time by a 2-bit policy input, which selects one of three orderings. Whichever NaN is chosen, a signalling NaN always leaves the block with its quiet bit set. A parameter selects one of two forms of the block: purely combinational, or with a single register stage loaded by an input strobe.

Top module: `nan_propagate_unit`

## Requirements
- R1: An operand is a NaN when its exponent field (bits 62:52) is all ones and its fraction (bits 51:0) is nonzero. Bit 51 set means quiet, and bit 51 clear means signalling. An all-ones exponent with a zero fraction is infinity, not a NaN.
- R2: A signalling NaN chosen as the result is output with bit 51 set and every other bit unchanged. A chosen quiet NaN (for example 0x7FF8300000000000) is output bit for bit unchanged.
- R3: With policy_sel = 0 (strict), the result is chosen by the first matching rule in this order:
  - if A is signalling, the result is quieted A;
  - otherwise, if B is signalling, the result is quieted B;
  - otherwise, if A is a quiet NaN, the result is A;
  - otherwise the result is B.
- R4: With policy_sel = 1 (wider fraction), the result is chosen by the first matching rule in this order:
  - if both operands are signalling, the result is the quieted operand whose 52-bit fraction is larger, and equal fractions select A;
  - otherwise, if A is signalling and B is quiet, the result is B;
  - otherwise, if A is a NaN, the result is A (quieted when signalling);
  - otherwise the result is B (quieted when signalling).
- R5: With policy_sel = 2 (first operand), the result is A (quieted when signalling) if A is any NaN. Otherwise it is B, quieted when signalling.
- R6: policy_sel = 3 gives the same result as policy_sel = 0.
- R7: nan_valid is high exactly when at least one operand is a NaN. It stays low for infinities and ordinary numbers.
- R8: invalid is high exactly when at least one operand is a signalling NaN, under every policy.
- R9: With the register stage on (REG_OUT = 1), the result, nan_valid and invalid for operands presented with in_valid high appear one clock later, with out_valid high for that one cycle. While in_valid is low, the outputs keep their values and out_valid is low.
- R10: While rst_n is low, out_valid, nan_valid and invalid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe; loads the output stage |
| op_a | input | 64 | First binary64 operand |
| op_b | input | 64 | Second binary64 operand |
| policy_sel | input | 2 | 0 strict, 1 wider fraction, 2 first operand, 3 as 0 |
| out_valid | output | 1 | Result stage holds a fresh decision |
| nan_result | output | 64 | Propagated NaN; meaningful when nan_valid is high |
| nan_valid | output | 1 | At least one operand was a NaN |
| invalid | output | 1 | At least one operand was a signalling NaN |

## Verification
With the default register stage, every output (result, nan_valid, invalid and out_valid) is due exactly one rising edge after the cycle in which in_valid is high. The bench drives operands on a falling edge and holds in_valid for one cycle. It compares the outputs on the next falling edge, after the capturing edge and well before the one that follows. Hold behaviour is checked one further edge later with in_valid low and different operands on the inputs. Reset is checked while rst_n is still low, since it clears the stage asynchronously.

// File: rtl/nanprop_pkg.sv
package nanprop_pkg;

  typedef enum logic [1:0] {
    CLS_NUM  = 2'd0,
    CLS_QNAN = 2'd1,
    CLS_SNAN = 2'd2
  } opclass_t;

  typedef enum logic [1:0] {
    POL_STRICT   = 2'd0,
    POL_WIDEFRAC = 2'd1,
    POL_FIRST    = 2'd2,
    POL_RSVD     = 2'd3
  } policy_t;

  localparam int NUM_OPS = 2;

endpackage

// File: rtl/nanprop_classify.sv
module nanprop_classify
  import nanprop_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] word_i,
  output opclass_t              cls_o,
  output logic [EXP_W+FRAC_W:0] quiet_o,
  output logic [FRAC_W-1:0]     frac_o
);
  localparam int QBIT = FRAC_W - 1;

  logic [EXP_W-1:0] exp_f;
  logic             exp_full;
  logic             frac_nz;

  always_comb begin
    exp_f    = word_i[EXP_W+FRAC_W-1:FRAC_W];
    frac_o   = word_i[FRAC_W-1:0];
    exp_full = &exp_f;
    frac_nz  = |frac_o;
    if (!(exp_full && frac_nz))   cls_o = CLS_NUM;
    else if (word_i[QBIT])        cls_o = CLS_QNAN;
    else                          cls_o = CLS_SNAN;
    quiet_o       = word_i;
    quiet_o[QBIT] = 1'b1;
  end

endmodule

// File: rtl/nanprop_select.sv
module nanprop_select
  import nanprop_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  opclass_t              cls_a,
  input  opclass_t              cls_b,
  input  logic [EXP_W+FRAC_W:0] quiet_a,
  input  logic [EXP_W+FRAC_W:0] quiet_b,
  input  logic [FRAC_W-1:0]     frac_a,
  input  logic [FRAC_W-1:0]     frac_b,
  input  logic [1:0]            policy_sel,
  output logic [EXP_W+FRAC_W:0] result,
  output logic                  any_nan,
  output logic                  any_snan
);
  logic    a_s, b_s, a_q, b_q, a_nan;
  policy_t pol;

  always_comb begin
    a_s      = (cls_a == CLS_SNAN);
    b_s      = (cls_b == CLS_SNAN);
    a_q      = (cls_a == CLS_QNAN);
    b_q      = (cls_b == CLS_QNAN);
    a_nan    = a_s || a_q;
    any_nan  = a_nan || b_s || b_q;
    any_snan = a_s || b_s;
    pol      = policy_t'(policy_sel);
    // Quieting a quiet NaN is the identity, so the quieted words serve for every pick.
    unique case (pol)
      POL_WIDEFRAC: begin
        if (a_s && b_s)      result = (frac_b > frac_a) ? quiet_b : quiet_a;
        else if (a_s && b_q) result = quiet_b;
        else if (a_nan)      result = quiet_a;
        else                 result = quiet_b;
      end
      POL_FIRST: begin
        result = a_nan ? quiet_a : quiet_b;
      end
      default: begin
        if (a_s)      result = quiet_a;
        else if (b_s) result = quiet_b;
        else if (a_q) result = quiet_a;
        else          result = quiet_b;
      end
    endcase
  end

endmodule

// File: rtl/nanprop_outstage.sv
module nanprop_outstage #(
  parameter int W       = 64,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] res_d,
  input  logic         nan_d,
  input  logic         inv_d,
  output logic         out_valid,
  output logic [W-1:0] res_q,
  output logic         nan_q,
  output logic         inv_q
);
  generate
    if (REG_OUT) begin : g_reg
      logic [W-1:0] res_n;
      logic         nan_n, inv_n;

      always_comb begin
        res_n = res_q;
        nan_n = nan_q;
        inv_n = inv_q;
        if (in_valid) begin
          res_n = res_d;
          nan_n = nan_d;
          inv_n = inv_d;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_valid <= 1'b0;
          res_q     <= '0;
          nan_q     <= 1'b0;
          inv_q     <= 1'b0;
        end else begin
          out_valid <= in_valid;
          res_q     <= res_n;
          nan_q     <= nan_n;
          inv_q     <= inv_n;
        end
      end
    end else begin : g_comb
      assign out_valid = in_valid;
      assign res_q     = res_d;
      assign nan_q     = nan_d;
      assign inv_q     = inv_d;
    end
  endgenerate

endmodule

// File: rtl/nan_propagate_unit.sv
module nan_propagate_unit
  import nanprop_pkg::*;
#(
  parameter int EXP_W   = 11,
  parameter int FRAC_W  = 52,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [EXP_W+FRAC_W:0] op_a,
  input  logic [EXP_W+FRAC_W:0] op_b,
  input  logic [1:0]            policy_sel,
  output logic                  out_valid,
  output logic [EXP_W+FRAC_W:0] nan_result,
  output logic                  nan_valid,
  output logic                  invalid
);
  localparam int W = EXP_W + FRAC_W + 1;

  logic [W-1:0]      ops   [NUM_OPS];
  opclass_t          cls   [NUM_OPS];
  logic [W-1:0]      quiet [NUM_OPS];
  logic [FRAC_W-1:0] frac  [NUM_OPS];

  logic [W-1:0] sel_res;
  logic         sel_nan, sel_snan;

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  generate
    for (genvar i = 0; i < NUM_OPS; i++) begin : g_cls
      nanprop_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
        .word_i (ops[i]),
        .cls_o  (cls[i]),
        .quiet_o(quiet[i]),
        .frac_o (frac[i])
      );
    end
  endgenerate

  nanprop_select #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_sel (
    .cls_a     (cls[0]),
    .cls_b     (cls[1]),
    .quiet_a   (quiet[0]),
    .quiet_b   (quiet[1]),
    .frac_a    (frac[0]),
    .frac_b    (frac[1]),
    .policy_sel(policy_sel),
    .result    (sel_res),
    .any_nan   (sel_nan),
    .any_snan  (sel_snan)
  );

  nanprop_outstage #(.W(W), .REG_OUT(REG_OUT)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .res_d    (sel_res),
    .nan_d    (sel_nan),
    .inv_d    (sel_snan),
    .out_valid(out_valid),
    .res_q    (nan_result),
    .nan_q    (nan_valid),
    .inv_q    (invalid)
  );

endmodule

// File: rtl/nanprop_checker.sv
module nanprop_checker #(
  parameter int EXP_W   = 11,
  parameter int FRAC_W  = 52,
  parameter bit REG_OUT = 1'b1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic [EXP_W+FRAC_W:0] op_a,
  input logic [EXP_W+FRAC_W:0] op_b,
  input logic [1:0]            policy_sel,
  input logic                  out_valid,
  input logic [EXP_W+FRAC_W:0] nan_result,
  input logic                  nan_valid,
  input logic                  invalid
);
  localparam int W    = EXP_W + FRAC_W + 1;
  localparam int QBIT = FRAC_W - 1;

  logic [W-1:0] ra, rb;
  logic [1:0]   rp;

  generate
    if (REG_OUT) begin : g_lag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ra <= '0;
          rb <= '0;
          rp <= '0;
        end else if (in_valid) begin
          ra <= op_a;
          rb <= op_b;
          rp <= policy_sel;
        end
      end
    end else begin : g_now
      assign ra = op_a;
      assign rb = op_b;
      assign rp = policy_sel;
    end
  endgenerate

  logic a_nan, b_nan, a_sig, b_sig;
  logic [W-1:0] qa, qb;
  always_comb begin
    a_nan = (&ra[W-2:FRAC_W]) && (|ra[FRAC_W-1:0]);
    b_nan = (&rb[W-2:FRAC_W]) && (|rb[FRAC_W-1:0]);
    a_sig = a_nan && !ra[QBIT];
    b_sig = b_nan && !rb[QBIT];
    qa = ra; qa[QBIT] = 1'b1;
    qb = rb; qb[QBIT] = 1'b1;
  end

  // R7
  a_r7_nan_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (nan_valid == (a_nan || b_nan)));
  // R8
  a_r8_invalid_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (invalid == (a_sig || b_sig)));
  // R2
  a_r2_result_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && nan_valid) |-> (nan_result[QBIT] && (&nan_result[W-2:FRAC_W])));
  // R3 and R6
  a_r3_strict_a_sig: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (rp == 2'd0 || rp == 2'd3) && a_sig) |-> (nan_result == qa));
  // R4
  a_r4_widefrac_tie: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && rp == 2'd1 && a_sig && b_sig && ra[FRAC_W-1:0] >= rb[FRAC_W-1:0])
      |-> (nan_result == qa));
  // R5
  a_r5_first_a_nan: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && rp == 2'd2 && a_nan) |-> (nan_result == qa));

  generate
    if (REG_OUT) begin : g_seq
      // R9
      a_r9_strobe_follow: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
      a_r9_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
      a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(nan_result) && $stable(nan_valid) && $stable(invalid)));
    end
  endgenerate

endmodule

bind nan_propagate_unit nanprop_checker #(
  .EXP_W(EXP_W), .FRAC_W(FRAC_W), .REG_OUT(REG_OUT)
) u_nanprop_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op_a      (op_a),
  .op_b      (op_b),
  .policy_sel(policy_sel),
  .out_valid (out_valid),
  .nan_result(nan_result),
  .nan_valid (nan_valid),
  .invalid   (invalid)
);

// File: tb/test_nan_propagate_unit.sv
module test_nan_propagate_unit;

  localparam logic [63:0] SA   = 64'h7FF0_0000_0000_1234; // signalling
  localparam logic [63:0] QSA  = 64'h7FF8_0000_0000_1234;
  localparam logic [63:0] SB   = 64'hFFF4_0000_0000_0001; // signalling, larger fraction
  localparam logic [63:0] QSB  = 64'hFFFC_0000_0000_0001;
  localparam logic [63:0] SA2  = 64'hFFF0_0000_0000_1234; // same fraction as SA
  localparam logic [63:0] QA   = 64'h7FF8_3000_0000_0000; // quiet
  localparam logic [63:0] QB   = 64'h7FFC_2000_0000_0000; // quiet
  localparam logic [63:0] ONE  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] INF  = 64'h7FF0_0000_0000_0000;

  typedef struct packed {
    logic [63:0] a;
    logic [63:0] b;
    logic [1:0]  pol;
    logic [63:0] res;
    logic        nv;
    logic        inv;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{SA,  SB,  2'd0, QSA, 1'b1, 1'b1, 8'd3},  // R3 both signalling
    '{SA,  SB,  2'd1, QSB, 1'b1, 1'b1, 8'd4},  // R4 larger fraction wins
    '{SA,  SB,  2'd2, QSA, 1'b1, 1'b1, 8'd5},  // R5
    '{SA,  QB,  2'd0, QSA, 1'b1, 1'b1, 8'd3},  // R3
    '{SA,  QB,  2'd1, QB,  1'b1, 1'b1, 8'd4},  // R4 quiet B beats signalling A
    '{SA,  QB,  2'd2, QSA, 1'b1, 1'b1, 8'd5},  // R5
    '{QA,  SB,  2'd0, QSB, 1'b1, 1'b1, 8'd3},  // R3 signalling B beats quiet A
    '{QA,  SB,  2'd1, QA,  1'b1, 1'b1, 8'd4},  // R4
    '{QA,  SB,  2'd2, QA,  1'b1, 1'b1, 8'd5},  // R5
    '{QA,  QB,  2'd0, QA,  1'b1, 1'b0, 8'd3},  // R3
    '{QA,  QB,  2'd1, QA,  1'b1, 1'b0, 8'd4},  // R4
    '{ONE, SB,  2'd2, QSB, 1'b1, 1'b1, 8'd5},  // R5 quieted B
    '{ONE, QB,  2'd1, QB,  1'b1, 1'b0, 8'd2},  // R2 quiet passes unchanged
    '{SA,  ONE, 2'd1, QSA, 1'b1, 1'b1, 8'd4},  // R4 lone signalling A
    '{QA,  SB,  2'd3, QSB, 1'b1, 1'b1, 8'd6},  // R6 reserved acts strict
    '{SA,  SA2, 2'd1, QSA, 1'b1, 1'b1, 8'd4},  // R4 tie goes to A
    '{QA,  ONE, 2'd0, QA,  1'b1, 1'b0, 8'd2},  // R2 0x7FF83... unchanged
    '{INF, ONE, 2'd0, '0,  1'b0, 1'b0, 8'd1},  // R1 infinity not NaN
    '{INF, INF, 2'd2, '0,  1'b0, 1'b0, 8'd7}   // R7 no NaN
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] op_a, op_b;
  logic [1:0]  policy_sel;
  logic        out_valid;
  logic [63:0] nan_result;
  logic        nan_valid;
  logic        invalid;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nan_propagate_unit i_nan_propagate_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .policy_sel(policy_sel), .out_valid(out_valid), .nan_result(nan_result),
    .nan_valid(nan_valid), .invalid(invalid)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic present(input logic [63:0] a, input logic [63:0] b, input logic [1:0] p);
    @(negedge clk);
    op_a = a; op_b = b; policy_sel = p; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0; policy_sel = '0;
    repeat (3) @(negedge clk);
    // R10 outputs low during reset
    check("R10 out_valid in reset", {63'd0, out_valid}, 64'd0);
    check("R10 nan_valid in reset", {63'd0, nan_valid}, 64'd0);
    check("R10 invalid in reset",   {63'd0, invalid},   64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      present(VECS[i].a, VECS[i].b, VECS[i].pol);
      // sampled one falling edge after the capturing rising edge
      check($sformatf("R%0d vec%0d out_valid", VECS[i].req, i), {63'd0, out_valid}, 64'd1);
      check($sformatf("R7 vec%0d nan_valid", i), {63'd0, nan_valid}, {63'd0, VECS[i].nv});
      check($sformatf("R8 vec%0d invalid", i), {63'd0, invalid}, {63'd0, VECS[i].inv});
      if (VECS[i].nv)
        check($sformatf("R%0d vec%0d result", VECS[i].req, i), nan_result, VECS[i].res);
    end

    // R9 hold: strobe low with new operands leaves outputs untouched
    present(SA, SB, 2'd1);
    check("R9 loaded result", nan_result, QSB);
    @(negedge clk);
    op_a = ONE; op_b = ONE; policy_sel = 2'd0;
    @(negedge clk);
    check("R9 out_valid low when idle", {63'd0, out_valid}, 64'd0);
    check("R9 result held", nan_result, QSB);
    check("R9 nan_valid held", {63'd0, nan_valid}, 64'd1);
    check("R9 invalid held", {63'd0, invalid}, 64'd1);

    // R1 quiet bit alone set: quiet NaN with only bit 51
    present(64'h7FF8_0000_0000_0000, ONE, 2'd0);
    check("R1 bit51-only is quiet NaN", {62'd0, nan_valid, invalid}, 64'd2);

    // R10 asynchronous reset clears a loaded stage
    present(SA, ONE, 2'd0);
    #1 rst_n = 1'b0;
    #1;
    check("R10 out_valid cleared", {63'd0, out_valid}, 64'd0);
    check("R10 flags cleared", {62'd0, nan_valid, invalid}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule